// File: doc/BRIEF.md
# Handshake Test-Vector Functional Monitor

This block sits on the tester side of a narrow parallel link to a processor under test. It drives the device's reset and holds it for a fixed number of cycles. It then raises a synchronization request and waits until the device answers with a strobed sync word. Once synchronized, it streams a fixed block of 32 sixteen-bit input words, one per strobe, spaced well apart. It then collects 32 result words and compares each against a stored expected value. After a completed pass it starts the next send phase directly, without a new sync. A mismatch increments a saturating error counter.

A watchdog runs while the monitor waits on the device, that is during synchronization and result collection. Every strobe from the device restarts it. When it expires the monitor resets the device and resynchronizes. The first timeout after a good pass is counted as an ordinary timeout. Any further timeout before another pass completes is counted as a repeated timeout, so a device that keeps hanging shows up separately from one that a reset clears. An independent exception request line is answered with a four-phase acknowledge and counted. Input vectors and expected results come from a small ROM computed at elaboration.

Top module: `hsk_test_monitor`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `dev_rst_o` is 1, `sync_req_o`, `tx_vld_o` and `exc_ack_o` are 0, and all four counters read 0. After `rst` falls, `dev_rst_o` stays high at least RST_CYC cycles, and only then does `sync_req_o` rise.
- R2: While `sync_req_o` is high, no word is sent. Only an `rx_vld_i` strobe whose `rx_data_i` equals SYNC_WORD (default 16'hC35A) ends synchronization, and then `sync_req_o` falls. Strobes carrying any other value leave the monitor synchronizing.
- R3: Each send phase emits exactly NUM_WORDS words, each as a one-cycle `tx_vld_o` pulse. Consecutive pulses are at least SEND_GAP cycles apart. Word i is the low 16 bits of (i * 16'h0B3D) XOR 16'h6C1E.
- R4: Result k is expected to equal the bitwise inverse of input word NUM_WORDS-1-k. Each differing result adds one to `mism_cnt_o`. Device strobes during the send phase are ignored and affect neither the count nor the result order.
- R5: During synchronization or result collection, if WD_LIMIT cycles pass with no `rx_vld_i` strobe, `dev_rst_o` is asserted for exactly RST_CYC cycles and synchronization starts again.
- R6: A watchdog expiry increments `tmo_cnt_o` if a pass has completed since the last expiry (or none has occurred yet). Otherwise it increments `rtmo_cnt_o`.
- R7: A rising `exc_req_i` gives `exc_ack_o` high on the next cycle and adds one to `exc_cnt_o`. The acknowledge stays high while the request stays high and falls the cycle after the request falls. Test traffic continues unaffected.
- R8: Every counter saturates at its all-ones value of CNT_W bits and holds there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_rst_o | output | 1 | Reset to the device under test |
| sync_req_o | output | 1 | Synchronization request |
| tx_data_o | output | DATA_W | Input word to the device |
| tx_vld_o | output | 1 | One-cycle strobe for tx_data_o |
| rx_data_i | input | DATA_W | Word from the device |
| rx_vld_i | input | 1 | One-cycle strobe for rx_data_i |
| exc_req_i | input | 1 | Exception request from the device |
| exc_ack_o | output | 1 | Exception acknowledge |
| mism_cnt_o | output | CNT_W | Result mismatch count |
| tmo_cnt_o | output | CNT_W | First-in-a-row timeout count |
| rtmo_cnt_o | output | CNT_W | Repeated timeout count |
| exc_cnt_o | output | CNT_W | Exception count |

## Verification
The hardest case to reach is the repeated timeout. It needs a device that goes silent partway through its results, then stays silent through the synchronization that follows its own reset. After that, the device must recover so that the streak is shown to end. The bench device model has two switches for this. One stops its results after ten words. The other ignores sync requests. The stimulus sets both at a pass boundary, releases them once two repeated timeouts are counted, and later hangs the device again to show that the next expiry counts as a first timeout.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

  typedef enum logic [1:0] {
    ST_DEVRST = 2'd0,
    ST_SYNC   = 2'd1,
    ST_SEND   = 2'd2,
    ST_RECV   = 2'd3
  } mon_state_t;

  localparam int unsigned NUM_CNT = 4;
  localparam int unsigned CI_MISM = 0;
  localparam int unsigned CI_TMO  = 1;
  localparam int unsigned CI_RTMO = 2;
  localparam int unsigned CI_EXC  = 3;

  // Input stimulus word for position idx (low bits are used)
  function automatic logic [31:0] vec_in(input int unsigned idx);
    logic [31:0] prod;
    prod = idx * 32'h0000_0B3D;
    return {16'h0000, prod[15:0] ^ 16'h6C1E};
  endfunction

  // Expected result at position idx for a block of n words
  function automatic logic [31:0] vec_exp(input int unsigned idx, input int unsigned n);
    logic [31:0] v;
    v = vec_in(n - 1 - idx);
    return {16'h0000, ~v[15:0]};
  endfunction

endpackage

// File: rtl/hsk_vec_rom.sv
module hsk_vec_rom #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned NUM_WORDS = 32,
  localparam int unsigned DEPTH    = 2 * NUM_WORDS,
  localparam int unsigned AW       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [AW-1:0]     addr,
  output logic [DATA_W-1:0] q
);
  // Lower half: stimulus words; upper half: expected results.
  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < int'(NUM_WORDS); i++) begin
      mem[i]             = DATA_W'(hsk_pkg::vec_in(i));
      mem[NUM_WORDS + i] = DATA_W'(hsk_pkg::vec_exp(i, NUM_WORDS));
    end
  end

  always_ff @(posedge clk) begin
    q <= mem[addr];
  end
endmodule

// File: rtl/hsk_watchdog.sv
module hsk_watchdog #(
  parameter int unsigned LIMIT = 4096,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic kick,
  output logic expire
);
  logic [CW-1:0] cnt;

  assign expire = run && !kick && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || kick || expire) cnt <= '0;
    else                               cnt <= cnt + 1'b1;
  end

  p_wd_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(LIMIT));
  p_wd_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));
endmodule

// File: rtl/hsk_sat_cnt.sv
module hsk_sat_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (rst)                     q <= '0;
    else if (inc && (q != MAXV)) q <= q + 1'b1;
  end

  p_sat_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (q == MAXV) |=> (q == MAXV));
  p_step_r8: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(q));
endmodule

// File: rtl/hsk_test_monitor.sv
module hsk_test_monitor #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned NUM_WORDS = 32,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned WD_LIMIT  = 4096,
  parameter int unsigned SEND_GAP  = 64,
  parameter int unsigned RST_CYC   = 16,
  parameter logic [DATA_W-1:0] SYNC_WORD = 16'hC35A
) (
  input  logic              clk,
  input  logic              rst,
  output logic              dev_rst_o,
  output logic              sync_req_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_vld_o,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_vld_i,
  input  logic              exc_req_i,
  output logic              exc_ack_o,
  output logic [CNT_W-1:0]  mism_cnt_o,
  output logic [CNT_W-1:0]  tmo_cnt_o,
  output logic [CNT_W-1:0]  rtmo_cnt_o,
  output logic [CNT_W-1:0]  exc_cnt_o
);
  import hsk_pkg::*;

  localparam int unsigned IW  = $clog2(NUM_WORDS);
  localparam int unsigned AW  = $clog2(2 * NUM_WORDS);
  localparam int unsigned GW  = $clog2(SEND_GAP + 1);
  localparam int unsigned RW  = $clog2(RST_CYC + 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(NUM_WORDS - 1);
  localparam logic [GW-1:0] GAP_LOAD = GW'(SEND_GAP - 1);
  localparam logic [RW-1:0] RST_LAST = RW'(RST_CYC - 1);

  initial begin
    if (SEND_GAP < 2) $error("SEND_GAP must be at least 2");
    if (RST_CYC < 1)  $error("RST_CYC must be at least 1");
  end

  mon_state_t        state;
  logic [IW-1:0]     snd_idx, rcv_idx;
  logic [GW-1:0]     gap_cnt;
  logic [RW-1:0]     rst_cnt;
  logic              streak;
  logic [AW-1:0]     rom_addr;
  logic [DATA_W-1:0] rom_q;
  logic              wd_run, wd_exp;
  logic              cap_vld;
  logic [DATA_W-1:0] cap_data;
  logic [NUM_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0]   cnt_q [NUM_CNT];

  // ROM: stimulus half while sending, expected half otherwise
  assign rom_addr = (state == ST_SEND) ? {1'b0, snd_idx} : {1'b1, rcv_idx};

  hsk_vec_rom #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)) u_rom (
    .clk  (clk),
    .addr (rom_addr),
    .q    (rom_q)
  );

  assign wd_run = (state == ST_SYNC) || (state == ST_RECV);

  hsk_watchdog #(.LIMIT(WD_LIMIT)) u_wd (
    .clk    (clk),
    .rst    (rst),
    .run    (wd_run),
    .kick   (rx_vld_i),
    .expire (wd_exp)
  );

  // Sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_DEVRST;
      dev_rst_o  <= 1'b1;
      sync_req_o <= 1'b0;
      tx_vld_o   <= 1'b0;
      tx_data_o  <= '0;
      snd_idx    <= '0;
      rcv_idx    <= '0;
      gap_cnt    <= '0;
      rst_cnt    <= '0;
      streak     <= 1'b0;
    end else begin
      tx_vld_o <= 1'b0;
      unique case (state)
        ST_DEVRST: begin
          dev_rst_o <= 1'b1;
          if (rst_cnt == RST_LAST) begin
            rst_cnt    <= '0;
            dev_rst_o  <= 1'b0;
            sync_req_o <= 1'b1;
            state      <= ST_SYNC;
          end else begin
            rst_cnt <= rst_cnt + 1'b1;
          end
        end
        ST_SYNC: begin
          if (wd_exp) begin
            state      <= ST_DEVRST;
            dev_rst_o  <= 1'b1;
            sync_req_o <= 1'b0;
            rst_cnt    <= '0;
            streak     <= 1'b1;
          end else if (rx_vld_i && (rx_data_i == SYNC_WORD)) begin
            state      <= ST_SEND;
            sync_req_o <= 1'b0;
            snd_idx    <= '0;
            gap_cnt    <= GAP_LOAD;
          end
        end
        ST_SEND: begin
          if (gap_cnt == '0) begin
            tx_data_o <= rom_q;
            tx_vld_o  <= 1'b1;
            gap_cnt   <= GAP_LOAD;
            if (snd_idx == LAST_IDX) begin
              state   <= ST_RECV;
              rcv_idx <= '0;
            end else begin
              snd_idx <= snd_idx + 1'b1;
            end
          end else begin
            gap_cnt <= gap_cnt - 1'b1;
          end
        end
        ST_RECV: begin
          if (wd_exp) begin
            state     <= ST_DEVRST;
            dev_rst_o <= 1'b1;
            rst_cnt   <= '0;
            streak    <= 1'b1;
          end else if (rx_vld_i) begin
            if (rcv_idx == LAST_IDX) begin
              rcv_idx <= '0;
              streak  <= 1'b0;
              state   <= ST_SEND;
              snd_idx <= '0;
              gap_cnt <= GAP_LOAD;
            end else begin
              rcv_idx <= rcv_idx + 1'b1;
            end
          end
        end
        default: state <= ST_DEVRST;
      endcase
    end
  end

  // Compare stage: the result is captured together with its ROM word
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_vld  <= 1'b0;
      cap_data <= '0;
    end else begin
      cap_vld  <= (state == ST_RECV) && rx_vld_i;
      cap_data <= rx_data_i;
    end
  end

  // Exception four-phase acknowledge
  always_ff @(posedge clk) begin
    if (rst) exc_ack_o <= 1'b0;
    else     exc_ack_o <= exc_req_i;
  end

  assign cnt_inc[CI_MISM] = cap_vld && (cap_data != rom_q);
  assign cnt_inc[CI_TMO]  = wd_exp && !streak;
  assign cnt_inc[CI_RTMO] = wd_exp && streak;
  assign cnt_inc[CI_EXC]  = exc_req_i && !exc_ack_o;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    hsk_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .inc (cnt_inc[g]),
      .q   (cnt_q[g])
    );
  end

  assign mism_cnt_o = cnt_q[CI_MISM];
  assign tmo_cnt_o  = cnt_q[CI_TMO];
  assign rtmo_cnt_o = cnt_q[CI_RTMO];
  assign exc_cnt_o  = cnt_q[CI_EXC];

  // Assertions
  p_quiet_in_reset_r1: assert property (@(posedge clk) disable iff (rst)
    dev_rst_o |-> (!tx_vld_o && !sync_req_o));
  p_no_send_in_sync_r2: assert property (@(posedge clk) disable iff (rst)
    sync_req_o |-> !tx_vld_o);
  p_strobe_gap_r3: assert property (@(posedge clk) disable iff (rst)
    tx_vld_o |=> !tx_vld_o);
  p_expire_resets_r5: assert property (@(posedge clk) disable iff (rst)
    wd_exp |=> dev_rst_o);
  p_ack_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (exc_ack_o && exc_req_i) |=> exc_ack_o);
  p_ack_release_r7: assert property (@(posedge clk) disable iff (rst)
    (exc_ack_o && !exc_req_i) |=> !exc_ack_o);
endmodule

// File: tb/sim_hsk_test_monitor.sv
module sim_hsk_test_monitor;
  localparam int DW = 16;
  localparam int NW = 32;
  localparam int CW = 4;
  localparam int WDL = 100;
  localparam int GAP = 8;
  localparam int RSTC = 4;
  localparam logic [15:0] SYNCW = 16'hC35A;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, dev_rst, sync_req, tx_vld, rx_vld, exc_req, exc_ack;
  logic [DW-1:0] tx_data, rx_data;
  logic [CW-1:0] mism, tmo, rtmo, excn;

  hsk_test_monitor #(.DATA_W(DW), .NUM_WORDS(NW), .CNT_W(CW), .WD_LIMIT(WDL),
                     .SEND_GAP(GAP), .RST_CYC(RSTC), .SYNC_WORD(SYNCW)) u0 (
    .clk(clk), .rst(rst), .dev_rst_o(dev_rst), .sync_req_o(sync_req),
    .tx_data_o(tx_data), .tx_vld_o(tx_vld), .rx_data_i(rx_data), .rx_vld_i(rx_vld),
    .exc_req_i(exc_req), .exc_ack_o(exc_ack), .mism_cnt_o(mism), .tmo_cnt_o(tmo),
    .rtmo_cnt_o(rtmo), .exc_cnt_o(excn));

  int errs = 0, checks = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] stim(input int i);
    logic [31:0] p;
    p = i * 32'h0B3D;
    return p[15:0] ^ 16'h6C1E;
  endfunction

  // Scoreboard queue of expected words on tx_data
  logic [15:0] sbq [$];

  // Device model controls
  bit mute = 0, hang = 0, spurious = 0, spur_done = 0, bad_pending = 0;
  int corrupt_a = -1, corrupt_b = -1;
  int iters = 0;
  int mst = 0, tmr = 0, rxn = 0, txn = 0;
  logic [15:0] dbuf [NW];

  task automatic push_block();
    for (int i = 0; i < NW; i++) sbq.push_back(stim(i));
  endtask

  initial begin
    rx_vld = 1'b0;
    rx_data = '0;
  end

  always @(negedge clk) begin
    rx_vld = 1'b0;
    if (bad_pending) begin
      // R2: a wrong sync word was strobed one edge ago
      chk(sync_req == 1'b1 && tx_vld == 1'b0, "R2", "wrong sync word accepted",
          sync_req, 1);
      bad_pending = 0;
    end
    if (rst || dev_rst) begin
      mst = 0; tmr = 0; rxn = 0; txn = 0;
    end else begin
      case (mst)
        0: if (sync_req) begin
          tmr++;
          if (!mute) begin
            if (tmr == 5) begin
              rx_data = 16'h1234; rx_vld = 1'b1; bad_pending = 1;
            end else if (tmr == 10) begin
              rx_data = SYNCW; rx_vld = 1'b1; mst = 1; rxn = 0; push_block();
            end
          end
        end
        1: begin
          if (tx_vld) begin
            dbuf[rxn] = tx_data; rxn++;
          end
          if (spurious && !spur_done && rxn == 3) begin
            rx_data = 16'h0000; rx_vld = 1'b1; spur_done = 1;
          end
          if (rxn == NW) begin
            mst = 2; tmr = 0; txn = 0;
          end
        end
        default: begin
          tmr++;
          if ((tmr % 6) == 0 && !(hang && txn >= 10)) begin
            logic [15:0] d;
            d = ~dbuf[NW - 1 - txn];
            if (txn == corrupt_a || txn == corrupt_b) d ^= 16'h0100;
            rx_data = d; rx_vld = 1'b1; txn++;
            if (txn == NW) begin
              mst = 1; rxn = 0; iters++; push_block();
            end
          end
        end
      endcase
    end
  end

  // Monitor: scoreboard pop, spacing, device reset pulse width
  int since = 1000, hi = 0, pulses = 0;
  bit first_pulse = 1;
  always @(negedge clk) begin
    if (!rst) begin
      since++;
      if (tx_vld) begin
        if (sbq.size() == 0) chk(0, "R3", "word with nothing expected", tx_data, 0);
        else begin
          logic [15:0] e;
          e = sbq.pop_front();
          chk(tx_data == e, "R3", "sent word", tx_data, e);
        end
        chk(since >= GAP, "R3", "strobe spacing", since, GAP);
        since = 0;
      end
      if (dev_rst) hi++;
      else if (hi > 0) begin
        if (!first_pulse) chk(hi == RSTC, "R5", "device reset width", hi, RSTC);
        else chk(hi >= RSTC, "R1", "initial device reset width", hi, RSTC);
        first_pulse = 0;
        pulses++;
        hi = 0;
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst = 1'b1; exc_req = 1'b0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(dev_rst == 1 && sync_req == 0 && tx_vld == 0 && exc_ack == 0, "R1",
        "reset outputs", {dev_rst, sync_req, tx_vld, exc_ack}, 4'b1000);
    chk(mism == 0 && tmo == 0 && rtmo == 0 && excn == 0, "R1", "reset counters",
        {mism, tmo, rtmo, excn}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(dev_rst == 1 && sync_req == 0, "R1", "first cycle after reset",
        {dev_rst, sync_req}, 2'b10);
    wait (sync_req);
    @(negedge clk);
    chk(dev_rst == 0, "R1", "sync only after device reset", dev_rst, 0);

    wait (iters == 2);
    repeat (3) @(negedge clk);
    chk(mism == 0, "R4", "clean passes", mism, 0);

    corrupt_a = 5;
    wait (iters == 3);
    corrupt_a = -1;
    repeat (3) @(negedge clk);
    chk(mism == 1, "R4", "one corrupt result", mism, 1);

    corrupt_a = 0; corrupt_b = NW - 1;
    wait (iters == 4);
    corrupt_a = -1; corrupt_b = -1;
    repeat (3) @(negedge clk);
    chk(mism == 3, "R4", "first and last corrupt", mism, 3);

    spurious = 1;
    wait (iters == 5);
    repeat (3) @(negedge clk);
    chk(spur_done == 1 && mism == 3, "R4", "strobe during send ignored", mism, 3);
    chk(tmo == 0 && rtmo == 0, "R5", "no timeout on healthy device", {tmo, rtmo}, 0);

    hang = 1; mute = 1;
    wait (tmo == 1);
    @(negedge clk);
    chk(rtmo == 0, "R6", "first timeout is not repeated", rtmo, 0);
    wait (rtmo == 2);
    hang = 0; mute = 0;
    @(negedge clk);
    chk(tmo == 1, "R6", "repeated timeouts counted separately", tmo, 1);
    wait (iters == 6);
    repeat (3) @(negedge clk);
    chk(tmo == 1 && rtmo == 2 && mism == 3, "R5", "recovery after resync",
        {tmo, rtmo, mism}, {4'd1, 4'd2, 4'd3});

    hang = 1;
    wait (tmo == 2);
    hang = 0;
    @(negedge clk);
    chk(rtmo == 2, "R6", "streak cleared by a completed pass", rtmo, 2);
    wait (iters == 7);

    for (int k = 0; k < 17; k++) begin
      exc_req = 1'b1;
      @(negedge clk);
      chk(exc_ack == 1, "R7", "ack follows request", exc_ack, 1);
      chk(excn == ((k + 1) > 15 ? 15 : k + 1), "R8", "exception count",
          excn, ((k + 1) > 15 ? 15 : k + 1));
      if (k == 0) begin
        repeat (3) @(negedge clk);
        chk(exc_ack == 1 && excn == 1, "R7", "ack held, single count", excn, 1);
      end
      exc_req = 1'b0;
      @(negedge clk);
      chk(exc_ack == 0, "R7", "ack released", exc_ack, 0);
      @(negedge clk);
    end

    wait (iters == 8);
    repeat (3) @(negedge clk);
    chk(mism == 3 && excn == 15, "R7", "traffic unaffected by exceptions",
        {mism, excn}, {4'd3, 4'd15});
    chk(pulses == 5, "R5", "device reset pulses", pulses, 5);
    finish_run();
  end
endmodule